// File: doc/BRIEF.md
# Segmented Parallel Prefix Scan Unit

This block takes a vector of sixteen 16-bit two's complement values, one per processing element, together with a per-lane section flag, and returns a vector of the same shape. Each output lane holds the combination of the lanes that come before it in its own section. The lane's own value is not included, so the scan is exclusive. One of five operators is applied: wrapping sum, signed maximum, signed minimum, bitwise AND or bitwise OR. The scan can run from lane 0 upward (forward) or from the top lane downward (backward).

In reduce mode, the lane where each section finishes in scan direction carries the combination of the whole section. Every other lane carries the operator identity. The result is built in log2(LANES) registered combining stages, each doubling the reach of the combination. Both sides use a valid/ready handshake. The whole pipeline advances together, so a new vector can enter on every cycle in which the output is not stalled.

Top module: `seg_scan_unit`

## Requirements
- R1: In forward scan mode (`in_backward`=0, `in_reduce`=0), output lane i equals the operator applied over input lanes s..i-1, where s is the first lane of i's section; the first lane of a section gets the operator identity.
- R2: `in_op` selects the operator: 0 wrapping sum modulo 2^16, 1 signed maximum, 2 signed minimum, 3 bitwise AND, 4 bitwise OR; codes 5, 6 and 7 behave as the sum.
- R3: The identity is 0x0000 for sum and OR, 0xFFFF for AND, 0x8000 for maximum and 0x7FFF for minimum.
- R4: In forward mode `in_seg[i]`=1 makes lane i the first lane of a new section; lane 0 always begins a section whatever `in_seg[0]` is.
- R5: In backward mode (`in_backward`=1), `in_seg[i]`=1 marks lane i as the highest lane of its section, and lane 15 always is. Output lane i equals the operator over lanes i+1 up to that highest lane of its section.
- R6: In reduce mode (`in_reduce`=1), the lane that finishes each section in scan direction holds the operator over all lanes of that section, and all other lanes hold the identity. In forward mode this is the highest lane of the section; in backward mode it is the lowest.
- R7: With `out_ready` held high, a vector accepted on a rising edge is presented with `out_valid` high right after the third following rising edge, and `out_valid` stays low before that.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold and `in_ready` is 0; whenever `out_valid`=0, `in_ready` is 1.
- R9: While and after synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1.
- R10: With `out_ready` high, one vector is accepted per cycle back to back, and results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Input vector taken on this edge when in_valid is high |
| in_data | input | LANES*WIDTH | Lane i in bits [i*WIDTH +: WIDTH] |
| in_seg | input | LANES | Section boundary flag per lane |
| in_op | input | 3 | Operator code |
| in_backward | input | 1 | 1 scans from the top lane downward |
| in_reduce | input | 1 | 1 selects section reduction |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_data | output | LANES*WIDTH | Result lane i in bits [i*WIDTH +: WIDTH] |

## Verification
The bench builds the unit with its default 16 lanes of 16 bits, which gives four combining stages. At this size every section pattern over the lanes can be produced directly. Sums can be driven past 0x7FFF into wraparound, and the signed extremes 0x8000 and 0x7FFF, which double as the max/min identities, can appear as real data. Random operators, directions, modes and handshake gaps are mixed with directed vectors for each operator, the unused operator codes, single-lane sections and long stalls.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int SCAN_LANES = 16;
    localparam int SCAN_WIDTH = 16;

    typedef enum logic [2:0] {
        OP_SUM = 3'd0,
        OP_MAX = 3'd1,
        OP_MIN = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4
    } scan_op_e;

    typedef struct packed {
        scan_op_e op;
        logic     backward;
        logic     reduce;
    } scan_ctrl_t;

    // Unused codes fall back to the sum (R2)
    function automatic scan_op_e decode_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_MAX;
            3'd2:    return OP_MIN;
            3'd3:    return OP_AND;
            3'd4:    return OP_OR;
            default: return OP_SUM;
        endcase
    endfunction

endpackage

// File: rtl/scan_prep.sv
module scan_prep
    import scan_pkg::*;
#(
    parameter int LANES = SCAN_LANES,
    parameter int WIDTH = SCAN_WIDTH
) (
    input  logic [LANES-1:0][WIDTH-1:0] raw_val,
    input  logic [LANES-1:0]            raw_seg,
    input  scan_ctrl_t                  ctrl,
    output logic [WIDTH-1:0]            ident,
    output logic [LANES-1:0][WIDTH-1:0] pre_val,
    output logic [LANES-1:0]            pre_start
);

    logic [LANES-1:0][WIDTH-1:0] ord_val;
    logic [LANES-1:0]            ord_seg;

    // Identity per operator (R3)
    always_comb begin
        case (ctrl.op)
            OP_AND:  ident = '1;
            OP_MAX:  ident = {1'b1, {(WIDTH-1){1'b0}}};
            OP_MIN:  ident = {1'b0, {(WIDTH-1){1'b1}}};
            default: ident = '0;
        endcase
    end

    // Backward mode works on the lane-reversed vector (R5)
    for (genvar i = 0; i < LANES; i++) begin : g_order
        assign ord_val[i] = ctrl.backward ? raw_val[LANES-1-i] : raw_val[i];
        assign ord_seg[i] = ctrl.backward ? raw_seg[LANES-1-i] : raw_seg[i];
    end

    // Exclusive scan: shift by one lane, identity at each section head (R1, R4)
    for (genvar i = 0; i < LANES; i++) begin : g_shift
        if (i == 0) begin : g_head
            assign pre_start[i] = 1'b1;
            assign pre_val[i]   = ctrl.reduce ? ord_val[i] : ident;
        end else begin : g_body
            assign pre_start[i] = ord_seg[i];
            assign pre_val[i]   = ctrl.reduce  ? ord_val[i]   :
                                  ord_seg[i]   ? ident        : ord_val[i-1];
        end
    end

endmodule

// File: rtl/scan_stage.sv
module scan_stage
    import scan_pkg::*;
#(
    parameter int LANES = SCAN_LANES,
    parameter int WIDTH = SCAN_WIDTH,
    parameter int DIST  = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        i_valid,
    input  scan_ctrl_t                  i_ctrl,
    input  logic [WIDTH-1:0]            i_ident,
    input  logic [LANES-1:0][WIDTH-1:0] i_val,
    input  logic [LANES-1:0]            i_seg,
    input  logic [LANES-1:0]            i_start,
    output logic                        o_valid,
    output scan_ctrl_t                  o_ctrl,
    output logic [WIDTH-1:0]            o_ident,
    output logic [LANES-1:0][WIDTH-1:0] o_val,
    output logic [LANES-1:0]            o_seg,
    output logic [LANES-1:0]            o_start
);

    logic [LANES-1:0][WIDTH-1:0] nxt_val;
    logic [LANES-1:0]            nxt_seg;

    function automatic logic [WIDTH-1:0] combine(input scan_op_e op,
                                                 input logic [WIDTH-1:0] a,
                                                 input logic [WIDTH-1:0] b);
        case (op)
            OP_MAX:  return ($signed(a) > $signed(b)) ? a : b;
            OP_MIN:  return ($signed(a) < $signed(b)) ? a : b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            default: return a + b;
        endcase
    endfunction

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        if (j >= DIST) begin : g_reach
            assign nxt_val[j] = i_seg[j] ? i_val[j]
                                         : combine(i_ctrl.op, i_val[j-DIST], i_val[j]);
            assign nxt_seg[j] = i_seg[j] | i_seg[j-DIST];
        end else begin : g_pass
            assign nxt_val[j] = i_val[j];
            assign nxt_seg[j] = i_seg[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
        end else if (en) begin
            o_valid <= i_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            o_ctrl  <= i_ctrl;
            o_ident <= i_ident;
            o_val   <= nxt_val;
            o_seg   <= nxt_seg;
            o_start <= i_start;
        end
    end

endmodule

// File: rtl/scan_finish.sv
module scan_finish
    import scan_pkg::*;
#(
    parameter int LANES = SCAN_LANES,
    parameter int WIDTH = SCAN_WIDTH
) (
    input  logic [LANES-1:0][WIDTH-1:0] fin_val,
    input  logic [LANES-1:0]            fin_start,
    input  scan_ctrl_t                  ctrl,
    input  logic [WIDTH-1:0]            ident,
    output logic [LANES-1:0][WIDTH-1:0] res_val
);

    logic [LANES-1:0][WIDTH-1:0] kept;
    logic [LANES-1:0]            tail;

    // A lane closes its section when the next lane opens one (R6)
    for (genvar j = 0; j < LANES; j++) begin : g_tail
        if (j == LANES-1) begin : g_top
            assign tail[j] = 1'b1;
        end else begin : g_mid
            assign tail[j] = fin_start[j+1];
        end
        assign kept[j] = (ctrl.reduce && !tail[j]) ? ident : fin_val[j];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_unorder
        assign res_val[i] = ctrl.backward ? kept[LANES-1-i] : kept[i];
    end

endmodule

// File: rtl/seg_scan_unit.sv
module seg_scan_unit
    import scan_pkg::*;
#(
    parameter int LANES = SCAN_LANES,
    parameter int WIDTH = SCAN_WIDTH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*WIDTH-1:0] in_data,
    input  logic [LANES-1:0]       in_seg,
    input  logic [2:0]             in_op,
    input  logic                   in_backward,
    input  logic                   in_reduce,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*WIDTH-1:0] out_data
);

    localparam int STAGES = $clog2(LANES);

    logic                        vld [0:STAGES];
    scan_ctrl_t                  ctl [0:STAGES];
    logic [WIDTH-1:0]            idv [0:STAGES];
    logic [LANES-1:0][WIDTH-1:0] val [0:STAGES];
    logic [LANES-1:0]            sgf [0:STAGES];
    logic [LANES-1:0]            stf [0:STAGES];
    logic [LANES-1:0][WIDTH-1:0] res;
    logic [LANES-1:0]            seg_final;
    logic                        advance;

    // The whole pipeline moves together unless the result is held (R8, R10)
    assign advance  = !vld[STAGES] || out_ready;
    assign in_ready = advance;

    assign vld[0]          = in_valid;
    assign ctl[0].op       = decode_op(in_op);
    assign ctl[0].backward = in_backward;
    assign ctl[0].reduce   = in_reduce;

    scan_prep #(.LANES(LANES), .WIDTH(WIDTH)) u_prep (
        .raw_val   (in_data),
        .raw_seg   (in_seg),
        .ctrl      (ctl[0]),
        .ident     (idv[0]),
        .pre_val   (val[0]),
        .pre_start (stf[0])
    );
    assign sgf[0] = stf[0];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        scan_stage #(.LANES(LANES), .WIDTH(WIDTH), .DIST(1 << k)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .en      (advance),
            .i_valid (vld[k]),
            .i_ctrl  (ctl[k]),
            .i_ident (idv[k]),
            .i_val   (val[k]),
            .i_seg   (sgf[k]),
            .i_start (stf[k]),
            .o_valid (vld[k+1]),
            .o_ctrl  (ctl[k+1]),
            .o_ident (idv[k+1]),
            .o_val   (val[k+1]),
            .o_seg   (sgf[k+1]),
            .o_start (stf[k+1])
        );
    end

    scan_finish #(.LANES(LANES), .WIDTH(WIDTH)) u_finish (
        .fin_val   (val[STAGES]),
        .fin_start (stf[STAGES]),
        .ctrl      (ctl[STAGES]),
        .ident     (idv[STAGES]),
        .res_val   (res)
    );

    assign seg_final = sgf[STAGES];
    assign out_valid = vld[STAGES];
    assign out_data  = res;

endmodule

// File: rtl/seg_scan_unit_chk.sv
module seg_scan_unit_chk #(
    parameter int LANES = 16,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [LANES*WIDTH-1:0] out_data,
    input logic [LANES-1:0]       scan_flags
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    a_r9_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

    a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r7_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(in_valid && in_ready, 4)
         && $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3))
        |-> out_valid);

    // Lane 0 heads a section, so the merged flags cover every lane (R4)
    a_r4_sections_cover: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (&scan_flags));

    a_r1_known_result: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_data));

endmodule

bind seg_scan_unit seg_scan_unit_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .scan_flags (seg_final)
);

// File: tb/seg_scan_unit_test.sv
module seg_scan_unit_test;

    localparam int N = 16;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic           in_ready;
    logic [N*W-1:0] in_data;
    logic [N-1:0]   in_seg;
    logic [2:0]     in_op;
    logic           in_backward;
    logic           in_reduce;
    logic           out_valid;
    logic           out_ready;
    logic [N*W-1:0] out_data;

    int  tests  = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic [N*W-1:0] exp_q [$];
    string          tag_q [$];

    always #10 clk = ~clk;

    seg_scan_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_seg(in_seg), .in_op(in_op),
        .in_backward(in_backward), .in_reduce(in_reduce),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [W-1:0] m_op(input logic [2:0] c, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
        case (c)
            3'd1:    m_op = ($signed(a) >= $signed(b)) ? a : b;
            3'd2:    m_op = ($signed(a) <= $signed(b)) ? a : b;
            3'd3:    m_op = a & b;
            3'd4:    m_op = a | b;
            default: m_op = a + b;
        endcase
    endfunction

    function automatic logic [W-1:0] m_id(input logic [2:0] c);
        case (c)
            3'd1:    m_id = 16'h8000;
            3'd2:    m_id = 16'h7FFF;
            3'd3:    m_id = 16'hFFFF;
            default: m_id = 16'h0000;
        endcase
    endfunction

    function automatic logic [N*W-1:0] model(input logic [N*W-1:0] d, input logic [N-1:0] sg,
                                             input logic [2:0] c, input logic bwd,
                                             input logic red);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) begin
            int lo = i;
            int hi = i;
            logic [W-1:0] acc = m_id(c);
            if (!bwd) begin
                while (lo > 0 && !sg[lo]) lo--;
                while (hi < N-1 && !sg[hi+1]) hi++;
                if (!red) begin
                    for (int j = lo; j < i; j++) acc = m_op(c, acc, d[j*W +: W]);
                end else if (i == hi) begin
                    for (int j = lo; j <= hi; j++) acc = m_op(c, acc, d[j*W +: W]);
                end
            end else begin
                while (hi < N-1 && !sg[hi]) hi++;
                while (lo > 0 && !sg[lo-1]) lo--;
                if (!red) begin
                    for (int j = i+1; j <= hi; j++) acc = m_op(c, acc, d[j*W +: W]);
                end else if (i == lo) begin
                    for (int j = lo; j <= hi; j++) acc = m_op(c, acc, d[j*W +: W]);
                end
            end
            r[i*W +: W] = acc;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Called just after a falling edge: looks at the coming rising edge
    task automatic tick(output bit acc);
        #1;
        acc = in_valid && in_ready;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected output", out_data, '0);
            end else begin
                check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
        end
        if (acc) begin
            exp_q.push_back(model(in_data, in_seg, in_op, in_backward, in_reduce));
            tag_q.push_back(in_reduce ? "R6 reduce" : (in_backward ? "R5 backward" :
                            (in_op > 3'd4 ? "R2 spare code" : "R1 forward")));
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [N*W-1:0] d, input logic [N-1:0] sg,
                        input logic [2:0] c, input logic bwd, input logic red);
        bit acc;
        in_data = d; in_seg = sg; in_op = c; in_backward = bwd; in_reduce = red;
        in_valid = 1'b1;
        acc = 1'b0;
        while (!acc) tick(acc);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        bit acc;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        for (int k = 0; k < 8; k++) tick(acc);
        check1("R10 all results delivered", exp_q.size() == 0, 1'b1);
    endtask

    function automatic logic [N*W-1:0] rand_vec();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) begin
            case ($urandom_range(0, 5))
                0:       v[i*W +: W] = 16'h7FFF;
                1:       v[i*W +: W] = 16'h8000;
                default: v[i*W +: W] = 16'($urandom);
            endcase
        end
        return v;
    endfunction

    function automatic logic [N*W-1:0] ramp();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = 16'(i + 1);
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        bit acc;
        logic [N*W-1:0] held;
        logic [N*W-1:0] v;
        void'($urandom(32'h1357_9bdf));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_seg = '0; in_op = '0;
        in_backward = 1'b0; in_reduce = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check1("R9 out_valid in reset", out_valid, 1'b0);
        check1("R9 in_ready in reset", in_ready, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check1("R9 out_valid after reset", out_valid, 1'b0);

        // R7: latency with the consumer always ready
        out_ready = 1'b1;
        in_data = ramp(); in_seg = '0; in_op = 3'd0; in_backward = 1'b0; in_reduce = 1'b0;
        in_valid = 1'b1;
        tick(acc);
        check1("R7 accepted", acc, 1'b1);
        in_valid = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            #1;
            check1($sformatf("R7 out_valid at edge %0d", k), out_valid, k == 4);
            tick(acc);
        end
        drain();

        // R1/R2/R3: every operator, one section
        for (int c = 0; c < 8; c++) send(rand_vec(), '0, 3'(c), 1'b0, 1'b0);
        // R2: wrapping sum
        v = '0; v[0 +: W] = 16'h7FFF; v[W +: W] = 16'h0001;
        send(v, '0, 3'd0, 1'b0, 1'b0);
        // R4: lane 0 flag ignored, every lane its own section, alternate sections
        send(ramp(), 16'h0001, 3'd0, 1'b0, 1'b0);
        send(ramp(), 16'hFFFF, 3'd1, 1'b0, 1'b0);
        send(ramp(), 16'h1111, 3'd0, 1'b0, 1'b0);
        // R5: backward scans
        send(ramp(), '0, 3'd0, 1'b1, 1'b0);
        send(ramp(), 16'h0808, 3'd0, 1'b1, 1'b0);
        send(rand_vec(), 16'h8421, 3'd2, 1'b1, 1'b0);
        // R6: reductions both ways
        send(ramp(), '0, 3'd0, 1'b0, 1'b1);
        send(ramp(), 16'h0100, 3'd4, 1'b0, 1'b1);
        send(rand_vec(), 16'h0F00, 3'd1, 1'b1, 1'b1);
        send(rand_vec(), 16'hFFFF, 3'd3, 1'b1, 1'b1);
        drain();

        // R8: stall holds data and blocks input
        out_ready = 1'b0;
        send(rand_vec(), 16'h0420, 3'd1, 1'b0, 1'b0);
        while (!out_valid) tick(acc);
        #1 held = out_data;
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1;
            tick(acc);
            check1("R8 no accept while stalled", acc, 1'b0);
            in_valid = 1'b0;
            check("R8 data held", out_data, held);
        end
        drain();

        // R10: back to back
        out_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            in_data = rand_vec(); in_seg = 16'($urandom); in_op = 3'($urandom_range(0, 7));
            in_backward = 1'($urandom); in_reduce = 1'($urandom); in_valid = 1'b1;
            tick(acc);
            check1("R10 accept every cycle", acc, 1'b1);
        end
        drain();

        // Random traffic with gaps on both sides
        for (int k = 0; k < 400; k++) begin
            in_valid = ($urandom_range(0, 3) != 0);
            out_ready = ($urandom_range(0, 3) != 0);
            if (!in_valid || acc) begin
                in_data = rand_vec(); in_seg = 16'($urandom); in_op = 3'($urandom_range(0, 7));
                in_backward = 1'($urandom); in_reduce = 1'($urandom);
            end
            tick(acc);
        end
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule